// File: doc/BRIEF.md
# Descriptor-Chained Scatter-Gather DMA Engine

This block is a bus-master mover that follows a chain of 8-byte region descriptors kept in memory. A one-cycle start pulse hands it the address of the descriptor table, the transfer direction and the number of bytes the current disk command still owes. For each descriptor it reads the table entry, waits a start-up latency that grows with the number of sectors the region covers, then moves the region as a series of bursts. No burst crosses a page boundary. The chain ends at the descriptor that carries the end-of-table flag.

The memory side is a simple request/acknowledge master. A request lasts one cycle and is only issued while the port is not busy. When the port reports busy at a request point, the engine waits a fixed number of cycles and tries again. Every moved byte is taken off the command byte counter. Completion is a one-cycle `done` pulse, with `error` raised in the same cycle when the run ended abnormally. Error causes are an address wrap, too much data for the command, bytes left over at the end of the table, or an abort.

Top module: `prd_dma_engine`

## Requirements
- R1: On start, the first request is a descriptor fetch (memDesc=1, memLen=8) at the start value with bits 1:0 cleared.
- R2: Each descriptor fetch that completes moves the descriptor pointer on by 8, so the fetch for entry i is at table base + 8*i.
- R3: A descriptor is returned on memRdata. Bits 31:0 are the region base address, bits 47:32 the byte count (0 stands for 65536), and bit 63 the end-of-table flag. `done` pulses for one cycle after the last burst of the flagged descriptor, and no request follows it.
- R4: Each data burst starts where the previous one ended. Its length is the smaller of the bytes left in the region and the bytes up to the next page boundary (page = PAGE_BYTES).
- R5: If the current address plus min(bytes left in region, PAGE_BYTES) exceeds 2^32, no burst is issued and the run ends with done and error.
- R6: No request is issued while memBusy is high. A request point that sees busy is retried exactly BACKOFF+1 cycles later.
- R7: With toMemory=1 (disk read), data bursts have memWrite=1. With toMemory=0 (disk write), memWrite=0. Descriptor fetches always have memWrite=0.
- R8: bytesLeft is loaded from cmdBytes at start and drops by each burst's length on its acknowledge. A burst longer than bytesLeft is not issued, and the run ends with error.
- R9: With the port idle, the first burst of a descriptor is requested DISK_DELAY + sectors + 2 cycles after the descriptor acknowledge, where sectors = byte count / 512.
- R10: At the end of the table, error is raised with done exactly when bytesLeft is not zero.
- R11: An abort during a run lets the outstanding burst finish, then stops further requests and ends with done and error. An abort while idle has no effect on the next run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | One-cycle start pulse, taken only while idle |
| startBase | input | 32 | Descriptor table address; bits 1:0 ignored |
| toMemory | input | 1 | 1 = data goes to memory (disk read), 0 = from memory |
| cmdBytes | input | CNT_W | Bytes the command expects in total |
| abortReq | input | 1 | Stop after the current burst |
| memReq | output | 1 | One-cycle memory request |
| memDesc | output | 1 | Request is a descriptor fetch |
| memWrite | output | 1 | Request writes memory |
| memAddr | output | 32 | Request address |
| memLen | output | log2(PAGE_BYTES)+1 | Request length in bytes |
| memBusy | input | 1 | Memory port cannot accept a request |
| memAck | input | 1 | Outstanding request completed |
| memRdata | input | 64 | Descriptor contents on a fetch acknowledge |
| bytesLeft | output | CNT_W | Remaining command bytes |
| engBusy | output | 1 | Engine is running |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Completion was abnormal (valid with done) |

## Verification
The hardest situation to reach from the ports is the backoff retry schedule. The retry points cannot be seen, so only the cycle of the eventual request shows whether the interval is right. A directed run holds the port busy from before start and releases it a fixed number of cycles after the first fetch attempt. The stimulus then predicts which retry slot catches the release and checks that the request lands in exactly that cycle. Randomly toggled busy in the random runs covers retries at both descriptor and burst request points, while checks confirm the chain is still walked in order.

// File: rtl/prd_dma_pkg.sv
`timescale 1ns/1ps
package prd_dma_pkg;
  typedef enum logic [2:0] {
    stIdle, stDescIssue, stDescWait, stDelay, stXferIssue, stXferWait, stBackoff
  } engState_t;

  typedef struct packed {
    logic loadStart;
    logic descAck;
    logic burstAck;
    logic selDesc;
  } dpCtl_t;

  localparam int DESC_BYTES = 8;
endpackage

// File: rtl/prd_dma_dp.sv
`timescale 1ns/1ps
module prd_dma_dp
  import prd_dma_pkg::*;
#(
  parameter int PAGE_BYTES   = 4096,
  parameter int CNT_W        = 24,
  parameter int DISK_DELAY   = 16,
  parameter int SECTOR_SHIFT = 9,
  parameter int DLY_W        = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  dpCtl_t                      ctl,
  input  logic [31:0]                 startBase,
  input  logic                        toMemory,
  input  logic [CNT_W-1:0]            cmdBytes,
  input  logic [63:0]                 memRdata,
  output logic [31:0]                 memAddr,
  output logic [$clog2(PAGE_BYTES):0] memLen,
  output logic                        memWrite,
  output logic [CNT_W-1:0]            bytesLeft,
  output logic                        wrapErr,
  output logic                        overErr,
  output logic                        lastBurst,
  output logic                        cmdEndZero,
  output logic                        eotFlag,
  output logic [DLY_W-1:0]            delayLoad
);
  localparam int PAGE_W = $clog2(PAGE_BYTES);
  localparam int LEN_W  = PAGE_W + 1;
  localparam int RGN_W  = 17;

  logic [31:0]      descPtr, regionAddr;
  logic [RGN_W-1:0] regionLeft, rgnLoad, preLen;
  logic [CNT_W-1:0] cmdLeft;
  logic             eotQ, dirQ;
  logic [LEN_W-1:0] pageRoom, burstLen;
  logic [15:0]      descCount;
  logic             descUnused;

  assign descUnused = ^{memRdata[62:48], startBase[1:0]};

  // Region length from the second descriptor word; zero encodes 64 KiB
  assign descCount = memRdata[47:32];
  assign rgnLoad   = (descCount == 16'd0) ? RGN_W'(65536) : {1'b0, descCount};
  assign delayLoad = DLY_W'(DISK_DELAY) + DLY_W'(rgnLoad >> SECTOR_SHIFT);

  // Page-bounded burst sizing
  assign pageRoom = LEN_W'(PAGE_BYTES) - {1'b0, regionAddr[PAGE_W-1:0]};
  always_comb begin
    if (RGN_W'(pageRoom) > regionLeft) burstLen = regionLeft[LEN_W-1:0];
    else                               burstLen = pageRoom;
  end
  assign preLen     = (regionLeft < RGN_W'(PAGE_BYTES)) ? regionLeft : RGN_W'(PAGE_BYTES);
  assign wrapErr    = ({1'b0, regionAddr} + 33'(preLen)) > 33'h1_0000_0000;
  assign overErr    = CNT_W'(burstLen) > cmdLeft;
  assign lastBurst  = RGN_W'(burstLen) == regionLeft;
  assign cmdEndZero = cmdLeft == CNT_W'(burstLen);
  assign eotFlag    = eotQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      descPtr    <= '0;
      regionAddr <= '0;
      regionLeft <= '0;
      cmdLeft    <= '0;
      eotQ       <= 1'b0;
      dirQ       <= 1'b0;
    end else begin
      if (ctl.loadStart) begin
        descPtr <= {startBase[31:2], 2'b00};
        cmdLeft <= cmdBytes;
        dirQ    <= toMemory;
      end
      if (ctl.descAck) begin
        descPtr    <= descPtr + 32'(DESC_BYTES);
        regionAddr <= memRdata[31:0];
        regionLeft <= rgnLoad;
        eotQ       <= memRdata[63];
      end
      if (ctl.burstAck) begin
        regionAddr <= regionAddr + 32'(burstLen);
        regionLeft <= regionLeft - RGN_W'(burstLen);
        cmdLeft    <= cmdLeft - CNT_W'(burstLen);
      end
    end
  end

  assign memAddr   = ctl.selDesc ? descPtr : regionAddr;
  assign memLen    = ctl.selDesc ? LEN_W'(DESC_BYTES) : burstLen;
  assign memWrite  = dirQ & ~ctl.selDesc;
  assign bytesLeft = cmdLeft;

  p_desc_align_r1: assert property (@(posedge clk) disable iff (!rstN)
    descPtr[1:0] == 2'b00);
  p_burst_in_page_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.burstAck |-> ({1'b0, regionAddr[PAGE_W-1:0]} + burstLen) <= LEN_W'(PAGE_BYTES));
  p_cmd_no_grow_r8: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.loadStart |=> cmdLeft <= $past(cmdLeft));
endmodule

// File: rtl/prd_dma_ctrl.sv
`timescale 1ns/1ps
module prd_dma_ctrl
  import prd_dma_pkg::*;
#(
  parameter int BACKOFF = 8,
  parameter int DLY_W   = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startValid,
  input  logic             abortReq,
  input  logic             memBusy,
  input  logic             memAck,
  input  logic             wrapErr,
  input  logic             overErr,
  input  logic             lastBurst,
  input  logic             cmdEndZero,
  input  logic             eotFlag,
  input  logic [DLY_W-1:0] delayLoad,
  output dpCtl_t           ctl,
  output logic             memReq,
  output logic             engBusy,
  output logic             done,
  output logic             error
);
  engState_t        state;
  logic [DLY_W-1:0] cnt;
  logic             retXfer, abortPend, doneQ, errQ;
  logic             descGo, xferGo;

  assign descGo = (state == stDescIssue) && !abortPend && !memBusy;
  assign xferGo = (state == stXferIssue) && !abortPend && !wrapErr && !overErr && !memBusy;
  assign memReq = descGo || xferGo;

  assign ctl.loadStart = (state == stIdle) && startValid;
  assign ctl.descAck   = (state == stDescWait) && memAck;
  assign ctl.burstAck  = (state == stXferWait) && memAck;
  assign ctl.selDesc   = (state == stDescIssue) || (state == stDescWait);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= stIdle;
      cnt       <= '0;
      retXfer   <= 1'b0;
      abortPend <= 1'b0;
      doneQ     <= 1'b0;
      errQ      <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      errQ  <= 1'b0;
      if (state != stIdle && abortReq) abortPend <= 1'b1;
      case (state)
        stIdle: if (startValid) begin
          state     <= stDescIssue;
          abortPend <= 1'b0;
        end
        stDescIssue: begin
          if (abortPend) begin
            state <= stIdle; doneQ <= 1'b1; errQ <= 1'b1;
          end else if (memBusy) begin
            state <= stBackoff; retXfer <= 1'b0; cnt <= DLY_W'(BACKOFF - 1);
          end else begin
            state <= stDescWait;
          end
        end
        stDescWait: if (memAck) begin
          state <= stDelay;
          cnt   <= delayLoad;
        end
        stDelay: begin
          if (cnt == '0) state <= stXferIssue;
          else           cnt   <= cnt - 1'b1;
        end
        stXferIssue: begin
          if (abortPend || wrapErr || overErr) begin
            state <= stIdle; doneQ <= 1'b1; errQ <= 1'b1;
          end else if (memBusy) begin
            state <= stBackoff; retXfer <= 1'b1; cnt <= DLY_W'(BACKOFF - 1);
          end else begin
            state <= stXferWait;
          end
        end
        stXferWait: if (memAck) begin
          if (lastBurst && eotFlag) begin
            state <= stIdle; doneQ <= 1'b1; errQ <= !cmdEndZero || abortPend;
          end else if (lastBurst) begin
            state <= stDescIssue;
          end else begin
            state <= stXferIssue;
          end
        end
        stBackoff: begin
          if (cnt == '0) state <= retXfer ? stXferIssue : stDescIssue;
          else           cnt   <= cnt - 1'b1;
        end
        default: state <= stIdle;
      endcase
    end
  end

  assign engBusy = state != stIdle;
  assign done    = doneQ;
  assign error   = errQ;

  p_no_req_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !memBusy);
  p_single_req_r6: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq);
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);
  p_err_with_done_r10: assert property (@(posedge clk) disable iff (!rstN)
    errQ |-> doneQ);
endmodule

// File: rtl/prd_dma_engine.sv
`timescale 1ns/1ps
module prd_dma_engine
  import prd_dma_pkg::*;
#(
  parameter int PAGE_BYTES = 4096,
  parameter int CNT_W      = 24,
  parameter int DISK_DELAY = 16,
  parameter int BACKOFF    = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        startValid,
  input  logic [31:0]                 startBase,
  input  logic                        toMemory,
  input  logic [CNT_W-1:0]            cmdBytes,
  input  logic                        abortReq,
  output logic                        memReq,
  output logic                        memDesc,
  output logic                        memWrite,
  output logic [31:0]                 memAddr,
  output logic [$clog2(PAGE_BYTES):0] memLen,
  input  logic                        memBusy,
  input  logic                        memAck,
  input  logic [63:0]                 memRdata,
  output logic [CNT_W-1:0]            bytesLeft,
  output logic                        engBusy,
  output logic                        done,
  output logic                        error
);
  localparam int DLY_W = 16;

  dpCtl_t           ctl;
  logic             wrapErr, overErr, lastBurst, cmdEndZero, eotFlag;
  logic [DLY_W-1:0] delayLoad;

  prd_dma_ctrl #(.BACKOFF(BACKOFF), .DLY_W(DLY_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startValid(startValid), .abortReq(abortReq),
    .memBusy(memBusy), .memAck(memAck), .wrapErr(wrapErr), .overErr(overErr),
    .lastBurst(lastBurst), .cmdEndZero(cmdEndZero), .eotFlag(eotFlag),
    .delayLoad(delayLoad), .ctl(ctl), .memReq(memReq), .engBusy(engBusy),
    .done(done), .error(error)
  );

  prd_dma_dp #(.PAGE_BYTES(PAGE_BYTES), .CNT_W(CNT_W), .DISK_DELAY(DISK_DELAY),
               .DLY_W(DLY_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .startBase(startBase), .toMemory(toMemory),
    .cmdBytes(cmdBytes), .memRdata(memRdata), .memAddr(memAddr), .memLen(memLen),
    .memWrite(memWrite), .bytesLeft(bytesLeft), .wrapErr(wrapErr), .overErr(overErr),
    .lastBurst(lastBurst), .cmdEndZero(cmdEndZero), .eotFlag(eotFlag),
    .delayLoad(delayLoad)
  );

  assign memDesc = ctl.selDesc;
endmodule

// File: tb/sim_prd_dma_engine.sv
`timescale 1ns/1ps
module sim_prd_dma_engine;
  localparam int PAGE = 4096, CNT_W = 24, DLY = 16, BO = 8, DROP = 20;

  logic clk = 1'b0, rstN = 1'b0;
  logic startValid = 1'b0, toMemory = 1'b0, abortReq = 1'b0;
  logic [31:0] startBase = '0;
  logic [CNT_W-1:0] cmdBytes = '0;
  logic memReq, memDesc, memWrite, engBusy, done, error;
  logic [31:0] memAddr;
  logic [12:0] memLen;
  logic memBusy = 1'b0, memAck = 1'b0;
  logic [63:0] memRdata = '0;
  logic [CNT_W-1:0] bytesLeft;

  prd_dma_engine #(.PAGE_BYTES(PAGE), .CNT_W(CNT_W), .DISK_DELAY(DLY), .BACKOFF(BO)) u0 (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startBase(startBase),
    .toMemory(toMemory), .cmdBytes(cmdBytes), .abortReq(abortReq), .memReq(memReq),
    .memDesc(memDesc), .memWrite(memWrite), .memAddr(memAddr), .memLen(memLen),
    .memBusy(memBusy), .memAck(memAck), .memRdata(memRdata), .bytesLeft(bytesLeft),
    .engBusy(engBusy), .done(done), .error(error));

  always #2 clk = ~clk;

  int nChk = 0, nFail = 0;
  longint cyc = 0;
  initial forever @(posedge clk) cyc++;

  // descriptor table and expected request list
  logic [31:0] dBase[4];
  logic [15:0] dCnt[4];
  bit dEot[4];
  int nDesc;
  logic [31:0] tblBase;
  logic [31:0] eAddr[64];
  int eLen[64], eLat[64];
  bit eDesc[64], eWr[64], eFirst[64];
  int nExp, reqIdx;
  bit expErr;
  longint expLeft, lastAck, expReqCyc;
  bit abortMode, abortSent, busyRand = 0, busyForce = 0, latOn, boTest;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] a, input int len, input bit ds,
                      input bit wr, input bit first, input int lat);
    if (nExp < 64) begin
      eAddr[nExp] = a; eLen[nExp] = len; eDesc[nExp] = ds;
      eWr[nExp] = wr; eFirst[nExp] = first; eLat[nExp] = lat;
      nExp++;
    end
  endtask

  task automatic buildExp(input longint cmdB, input bit dir, input bit abortM);
    longint cmd = cmdB;
    bit stop = 0;
    nExp = 0; expErr = 0;
    for (int i = 0; i < nDesc && !stop; i++) begin
      longint a = dBase[i];
      longint rl = (dCnt[i] == 0) ? 65536 : dCnt[i];
      int lat = DLY + int'(rl / 512);
      bit first = 1;
      push(tblBase + 32'(8 * i), 8, 1, 0, 0, 0);
      while (!stop && rl > 0) begin
        longint pre = (rl < PAGE) ? rl : PAGE;
        longint room = PAGE - (a % PAGE);
        longint len = (rl < room) ? rl : room;
        if (a + pre > 64'h1_0000_0000) begin expErr = 1; stop = 1; end
        else if (len > cmd) begin expErr = 1; stop = 1; end
        else begin
          push(a[31:0], int'(len), 0, dir, first, lat);
          first = 0; cmd -= len; rl -= len; a += len;
          if (abortM) begin expErr = 1; stop = 1; end
        end
      end
      if (!stop && dEot[i]) begin stop = 1; if (cmd != 0) expErr = 1; end
    end
    expLeft = cmd;
  endtask

  task automatic serve();
    int lat;
    logic [31:0] di;
    bit isDesc, sentHere;
    isDesc = memDesc;
    sentHere = 0;
    if (reqIdx >= nExp) chk(0, "R3", "request after expected end", memAddr, 0);
    else begin
      chk(memAddr == eAddr[reqIdx], eDesc[reqIdx] ? "R2" : "R4", "request address",
          memAddr, eAddr[reqIdx]);
      chk(memLen == 13'(eLen[reqIdx]) && memDesc == eDesc[reqIdx],
          eDesc[reqIdx] ? "R1" : "R4", "request length", memLen, eLen[reqIdx]);
      chk(memWrite == eWr[reqIdx], "R7", "write flag", memWrite, eWr[reqIdx]);
      if (eFirst[reqIdx] && latOn)
        chk(cyc - lastAck == eLat[reqIdx] + 2, "R9", "descriptor start latency",
            cyc - lastAck, eLat[reqIdx] + 2);
      if (boTest && reqIdx == 0)
        chk(cyc == expReqCyc, "R6", "request cycle after backoff", cyc, expReqCyc);
    end
    if (abortMode && !isDesc && !abortSent) begin
      abortReq = 1'b1; abortSent = 1; sentHere = 1;
    end
    di = (memAddr - tblBase) >> 3;
    lat = 1 + int'($urandom % 3);
    repeat (lat) begin @(negedge clk); if (sentHere) abortReq = 1'b0; end
    memRdata = (isDesc && di < 32'(nDesc)) ?
               {dEot[di], 15'd0, dCnt[di], dBase[di]} : 64'd0;
    memAck = 1'b1;
    if (isDesc) lastAck = cyc;
    @(negedge clk);
    memAck = 1'b0;
    reqIdx++;
  endtask

  initial begin
    @(negedge clk);
    forever begin
      if (memReq) serve();
      else @(negedge clk);
    end
  end

  initial forever begin
    @(posedge clk); #1;
    memBusy = busyRand ? ($urandom % 4 == 0) : busyForce;
  end

  task automatic runScen(input logic [31:0] sv, input bit dir, input longint cmdB,
                         input bit abortM, input bit rnd, input bit lat, input bit bo,
                         input string tag);
    longint k;
    int t = 0;
    bit got = 0, gErr;
    longint gLeft;
    tblBase = sv & ~32'h3;
    buildExp(cmdB, dir, abortM);
    reqIdx = 0; abortMode = abortM; abortSent = 0; latOn = lat; boTest = bo;
    if (bo) begin busyForce = 1; repeat (3) @(negedge clk); end
    busyRand = rnd;
    startBase = sv; toMemory = dir; cmdBytes = CNT_W'(cmdB); startValid = 1'b1;
    k = cyc + 1;
    expReqCyc = k + ((DROP + BO) / (BO + 1)) * (BO + 1);
    @(negedge clk);
    startValid = 1'b0;
    while (!got && t < 100000) begin
      if (bo && cyc == k + DROP - 1) busyForce = 0;
      if (done) got = 1;
      else begin @(negedge clk); t++; end
    end
    gErr = error; gLeft = bytesLeft;
    busyRand = 0; busyForce = 0;
    chk(got, "R3", {tag, " done seen"}, got, 1);
    chk(gErr == expErr, tag, "error flag", gErr, expErr);
    chk(gLeft == expLeft, "R8", {tag, " bytes left"}, gLeft, expLeft);
    repeat (3) @(negedge clk);
    chk(reqIdx == nExp, "R3", {tag, " request count"}, reqIdx, nExp);
    chk(!engBusy, "R3", {tag, " idle after done"}, engBusy, 0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!engBusy && !done && !memReq, "R3", "reset idle", {engBusy, done, memReq}, 0);
    chk(bytesLeft == 0, "R8", "reset byte count", bytesLeft, 0);

    // R1 R3 R7 R9 R10: single clean descriptor, disk read
    nDesc = 1; dBase[0] = 32'h0000_1000; dCnt[0] = 16'd1024; dEot[0] = 1;
    runScen(32'h0004_0000, 1, 1024, 0, 0, 1, 0, "R10");
    // R4: region crossing a page boundary, disk write
    dBase[0] = 32'h0000_2F00; dCnt[0] = 16'h0300;
    runScen(32'h0004_0100, 0, 768, 0, 0, 1, 0, "R4");
    // R3: zero count means 64 KiB
    dBase[0] = 32'h0001_0000; dCnt[0] = 16'd0;
    runScen(32'h0004_0200, 1, 65536, 0, 0, 1, 0, "R3");
    // R1 R2: three-entry chain, low start bits set
    nDesc = 3;
    dBase[0] = 32'h0010_0800; dCnt[0] = 16'd2048; dEot[0] = 0;
    dBase[1] = 32'h0020_0000; dCnt[1] = 16'd512;  dEot[1] = 0;
    dBase[2] = 32'h0030_0E00; dCnt[2] = 16'd5120; dEot[2] = 1;
    runScen(32'h0004_0303, 0, 7680, 0, 0, 1, 0, "R2");
    // R5: wrap at top of address space
    nDesc = 1; dBase[0] = 32'hFFFF_F800; dCnt[0] = 16'h1000; dEot[0] = 1;
    runScen(32'h0004_0400, 1, 4096, 0, 0, 0, 0, "R5");
    // R8: burst larger than remaining command bytes
    dBase[0] = 32'h0000_4000; dCnt[0] = 16'd1024;
    runScen(32'h0004_0500, 1, 512, 0, 0, 0, 0, "R8");
    // R10: bytes left over at end of table
    runScen(32'h0004_0600, 0, 1536, 0, 0, 0, 0, "R10");
    // R11: abort during first burst
    dBase[0] = 32'h0000_8000; dCnt[0] = 16'd8192;
    runScen(32'h0004_0700, 1, 8192, 1, 0, 0, 0, "R11");
    // R11: abort while idle is ignored
    abortReq = 1'b1; @(negedge clk); abortReq = 1'b0; repeat (2) @(negedge clk);
    dCnt[0] = 16'd2048;
    runScen(32'h0004_0800, 1, 2048, 0, 0, 1, 0, "R11");
    // R6: fixed backoff schedule
    dBase[0] = 32'h0000_C000; dCnt[0] = 16'd1024;
    runScen(32'h0004_0900, 0, 1024, 0, 0, 0, 1, "R6");

    // random chains with random busy
    for (int s = 0; s < 20; s++) begin
      longint tot = 0, cmd;
      int v;
      nDesc = 1 + int'($urandom % 3);
      for (int i = 0; i < nDesc; i++) begin
        dBase[i] = 32'h0100_0000 + 32'($urandom % 32'h0004_0000);
        dCnt[i] = 16'(1 + $urandom % 9000);
        dEot[i] = (i == nDesc - 1);
        tot += dCnt[i];
      end
      v = int'($urandom % 4);
      cmd = (v == 0 && tot > 256) ? tot - 256 : (v == 1 ? tot + 512 : tot);
      runScen(32'h0008_0000 + 32'(s * 64) + 32'($urandom % 4), 1'($urandom % 2),
              cmd, 0, 1, 0, 0, "R10");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL R3 watchdog expired: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule